// File: doc/BRIEF.md
# Security-State Stack Pointer Tracker

This block follows a processor core's security state (Secure or Non-Secure) and its execution mode (Thread or Handler), and from the two it picks which of four banked stack pointers is live: the main or the process pointer of either security state. The mode is not held as a flag of its own. It comes from an exception-number register, where zero means Thread and any other value means Handler. That register is loaded on exception entry and on exception return, and it is left alone by calls into the Secure state and by the returns from them.

Calls into the Secure state go through a gateway event. The gateway only switches state when its fetch came from the callable region. Each accepted call records the caller's mode on a small return-state stack. A marked return pops that entry and puts the Non-Secure state back. The block also holds the four pointer registers and one lower limit per process pointer. It applies register writes, refusing writes to Secure-side registers from the Non-Secure state. It applies push decrements to the live pointer and refuses any push that would take a process pointer under its limit.

Top module: `sst_tracker`

## Requirements
- R1: After reset the block is Secure, in Thread mode, with `sp_sel` = 3 and every pointer and limit register at zero; both fault outputs are low.
- R2: Exception entry loads `exc_entry_num` and the state from `exc_entry_secure`. Exception return loads `exc_return_num` and the state from `exc_return_secure`. Mode is Handler exactly when the loaded number is nonzero.
- R3: `sp_sel` has bit 1 = Secure and bit 0 = process pointer. Handler mode selects the main pointer of the current state and Thread mode selects the process pointer. `sp_active` shows the selected register.
- R4: A gateway taken in the Non-Secure state from the callable region, with fewer than 4 calls outstanding, makes the block Secure on the next cycle and leaves the mode unchanged. From Handler this gives `sp_sel` = 2, and from Thread it gives `sp_sel` = 3.
- R5: A gateway in the Non-Secure state that is not from the callable region changes nothing and raises `sec_fault` for one cycle.
- R6: A gateway while already Secure changes nothing and raises no fault.
- R7: At most 4 calls are outstanding. A fifth accepted-looking gateway changes nothing and raises `sec_fault`.
- R8: A marked return while Secure, with a call outstanding and in the same mode as when that call was made, restores the Non-Secure state. The mode is unchanged, so the pointer selection is the one in force before the call.
- R9: A marked return with no call outstanding, while Non-Secure, or in a different mode from the matching call, changes nothing and raises `sec_fault`.
- R10: A register write with `wr_sel` 0/1/2/3 loads the Non-Secure main, Non-Secure process, Secure main or Secure process pointer. With 4 or 5 it loads the Non-Secure or Secure process limit. The value is visible on the next cycle.
- R11: Writes with `wr_sel` 2, 3 or 5 made while Non-Secure are ignored.
- R12: A push lowers the live pointer by `push_bytes`. When the live pointer is a process pointer and the result would be below its limit, or would wrap below zero, the push is dropped and `limit_fault` is high for one cycle. Main pointers are not limit-checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gw_valid | input | 1 | Gateway entry event |
| gw_callable | input | 1 | Gateway fetch came from the callable region |
| nsret_valid | input | 1 | Function return marked Secure-to-Non-Secure |
| exc_entry_valid | input | 1 | Exception entry event |
| exc_entry_secure | input | 1 | Security state targeted by the exception |
| exc_entry_num | input | XW (9) | Exception number loaded on entry |
| exc_return_valid | input | 1 | Exception return event |
| exc_return_secure | input | 1 | Security state returned to |
| exc_return_num | input | XW (9) | Exception number restored on return |
| wr_valid | input | 1 | Register write event |
| wr_sel | input | 3 | Register select (see R10) |
| wr_data | input | DW (32) | Write value |
| push_valid | input | 1 | Push event on the live pointer |
| push_bytes | input | PW (8) | Bytes to push |
| is_secure | output | 1 | Current security state |
| is_handler | output | 1 | Current mode is Handler |
| sp_sel | output | 2 | Live pointer select (see R3) |
| sp_active | output | DW (32) | Live pointer value |
| sec_fault | output | 1 | Security fault pulse |
| limit_fault | output | 1 | Stack-limit fault pulse |

## Verification
The properties assume that at most one of the six event inputs is high in a cycle, and each antecedent is gated by that condition. The block resolves overlapping events by a fixed priority, but the expected-state reasoning in the properties only holds for a lone event. The stimulus drives exactly one event per step and returns all event inputs to idle before it samples the outputs. The push property also assumes a nonzero byte count, and the bench always pushes at least four bytes.

// File: rtl/sst_pkg.sv
package sst_pkg;

  // Live pointer select: bit 1 = Secure bank, bit 0 = process pointer
  typedef enum logic [1:0] {
    SP_MAIN_NS = 2'b00,
    SP_PROC_NS = 2'b01,
    SP_MAIN_S  = 2'b10,
    SP_PROC_S  = 2'b11
  } sp_sel_e;

  // Write targets; codes 0..3 line up with sp_sel_e
  typedef enum logic [2:0] {
    WR_MAIN_NS = 3'd0,
    WR_PROC_NS = 3'd1,
    WR_MAIN_S  = 3'd2,
    WR_PROC_S  = 3'd3,
    WR_LIM_NS  = 3'd4,
    WR_LIM_S   = 3'd5
  } wr_sel_e;

  localparam int NUM_SP  = 4;
  localparam int NUM_LIM = 2;

  function automatic logic sec_bank(input logic [2:0] sel);
    return (sel == WR_MAIN_S) || (sel == WR_PROC_S) || (sel == WR_LIM_S);
  endfunction

endpackage

// File: rtl/sst_rst_sync.sv
module sst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sst_retstack.sv
module sst_retstack #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_en,
  input  logic push_mode,
  input  logic pop_en,
  output logic empty,
  output logic full,
  output logic top_mode
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          mode_vec [DEPTH];

  always_comb begin
    cnt_en = push_en | pop_en;
    cnt_d  = cnt_q;
    if (push_en)     cnt_d = cnt_q + 1'b1;
    else if (pop_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ent_q;
    logic ent_en;
    assign ent_en = push_en && (cnt_q == CW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= 1'b0;
      else if (ent_en) ent_q <= push_mode;
    end
    assign mode_vec[i] = ent_q;
  end

  always_comb begin
    top_mode = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CW'(i + 1)) top_mode = mode_vec[i];
    end
  end

endmodule

// File: rtl/sst_state.sv
module sst_state #(
  parameter int XW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gw_valid,
  input  logic          gw_callable,
  input  logic          nsret_valid,
  input  logic          exc_entry_valid,
  input  logic          exc_entry_secure,
  input  logic [XW-1:0] exc_entry_num,
  input  logic          exc_return_valid,
  input  logic          exc_return_secure,
  input  logic [XW-1:0] exc_return_num,
  input  logic          rs_empty,
  input  logic          rs_full,
  input  logic          rs_top_mode,
  output logic          rs_push,
  output logic          rs_pop,
  output logic          secure,
  output logic          handler,
  output logic          sec_fault
);

  logic          sec_q, sec_d;
  logic [XW-1:0] xn_q, xn_d;
  logic          flt_q, flt_d;
  logic          st_en;

  assign handler = |xn_q;

  // R4 R5 R6 R7 R8 R9 R2: event resolution, gateway highest priority
  always_comb begin
    sec_d   = sec_q;
    xn_d    = xn_q;
    flt_d   = 1'b0;
    rs_push = 1'b0;
    rs_pop  = 1'b0;
    if (gw_valid) begin
      if (!sec_q) begin
        if (!gw_callable || rs_full) begin
          flt_d = 1'b1;
        end else begin
          sec_d   = 1'b1;
          rs_push = 1'b1;
        end
      end
    end else if (nsret_valid) begin
      if (!sec_q || rs_empty || (rs_top_mode != handler)) begin
        flt_d = 1'b1;
      end else begin
        sec_d  = 1'b0;
        rs_pop = 1'b1;
      end
    end else if (exc_entry_valid) begin
      xn_d  = exc_entry_num;
      sec_d = exc_entry_secure;
    end else if (exc_return_valid) begin
      xn_d  = exc_return_num;
      sec_d = exc_return_secure;
    end
  end

  assign st_en = gw_valid | nsret_valid | exc_entry_valid | exc_return_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 1'b1;
      xn_q  <= '0;
    end else if (st_en) begin
      sec_q <= sec_d;
      xn_q  <= xn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_q <= 1'b0;
    else        flt_q <= flt_d;
  end

  assign secure    = sec_q;
  assign sec_fault = flt_q;

endmodule

// File: rtl/sst_spbank.sv
module sst_spbank
  import sst_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          secure,
  input  logic          handler,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          push_en,
  input  logic [PW-1:0] push_bytes,
  output logic [1:0]    sel,
  output logic [DW-1:0] active,
  output logic          lim_fault
);

  logic [DW-1:0] sp_vec  [NUM_SP];
  logic [DW-1:0] lim_vec [NUM_LIM];
  logic [DW:0]   diff;
  logic          viol, push_ok, wr_ok;
  logic          lf_q;

  // R3: bank from state, main pointer in Handler
  assign sel    = {secure, ~handler};
  assign active = sp_vec[sel];

  // R12: unsigned borrow flags a wrap below zero
  assign diff    = {1'b0, active} - {{(DW + 1 - PW){1'b0}}, push_bytes};
  assign viol    = push_en && sel[0] && (diff[DW] || (diff[DW-1:0] < lim_vec[secure]));
  assign push_ok = push_en && !viol;

  // R11: Secure-side writes need the Secure state
  assign wr_ok = wr_en && (secure || !sec_bank(wr_sel));

  for (genvar i = 0; i < NUM_SP; i++) begin : g_sp
    logic [DW-1:0] q, d;
    logic          en;
    always_comb begin
      en = 1'b0;
      d  = q;
      if (wr_ok && (wr_sel == 3'(i))) begin
        en = 1'b1;
        d  = wr_data;
      end else if (push_ok && (sel == 2'(i))) begin
        en = 1'b1;
        d  = diff[DW-1:0];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end
    assign sp_vec[i] = q;
  end

  for (genvar j = 0; j < NUM_LIM; j++) begin : g_lim
    logic [DW-1:0] q;
    logic          en;
    assign en = wr_ok && (wr_sel == 3'(NUM_SP + j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wr_data;
    end
    assign lim_vec[j] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lf_q <= 1'b0;
    else        lf_q <= viol;
  end

  assign lim_fault = lf_q;

endmodule

// File: rtl/sst_tracker.sv
module sst_tracker #(
  parameter int DW        = 32,
  parameter int XW        = 9,
  parameter int PW        = 8,
  parameter int RET_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gw_valid,
  input  logic          gw_callable,
  input  logic          nsret_valid,
  input  logic          exc_entry_valid,
  input  logic          exc_entry_secure,
  input  logic [XW-1:0] exc_entry_num,
  input  logic          exc_return_valid,
  input  logic          exc_return_secure,
  input  logic [XW-1:0] exc_return_num,
  input  logic          wr_valid,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          push_valid,
  input  logic [PW-1:0] push_bytes,
  output logic          is_secure,
  output logic          is_handler,
  output logic [1:0]    sp_sel,
  output logic [DW-1:0] sp_active,
  output logic          sec_fault,
  output logic          limit_fault
);

  logic rst_i_n;
  logic rs_push, rs_pop, rs_empty, rs_full, rs_top;
  logic ctrl_evt, wr_en, push_en;

  sst_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sst_state #(.XW(XW)) u_state (
    .clk               (clk),
    .rst_n             (rst_i_n),
    .gw_valid          (gw_valid),
    .gw_callable       (gw_callable),
    .nsret_valid       (nsret_valid),
    .exc_entry_valid   (exc_entry_valid),
    .exc_entry_secure  (exc_entry_secure),
    .exc_entry_num     (exc_entry_num),
    .exc_return_valid  (exc_return_valid),
    .exc_return_secure (exc_return_secure),
    .exc_return_num    (exc_return_num),
    .rs_empty          (rs_empty),
    .rs_full           (rs_full),
    .rs_top_mode       (rs_top),
    .rs_push           (rs_push),
    .rs_pop            (rs_pop),
    .secure            (is_secure),
    .handler           (is_handler),
    .sec_fault         (sec_fault)
  );

  // R7: caller mode recorded per outstanding call
  sst_retstack #(.DEPTH(RET_DEPTH)) u_rs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .push_en   (rs_push),
    .push_mode (is_handler),
    .pop_en    (rs_pop),
    .empty     (rs_empty),
    .full      (rs_full),
    .top_mode  (rs_top)
  );

  // state events outrank writes, writes outrank pushes
  assign ctrl_evt = gw_valid | nsret_valid | exc_entry_valid | exc_return_valid;
  assign wr_en    = wr_valid & ~ctrl_evt;
  assign push_en  = push_valid & ~ctrl_evt & ~wr_valid;

  sst_spbank #(.DW(DW), .PW(PW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .secure     (is_secure),
    .handler    (is_handler),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .push_en    (push_en),
    .push_bytes (push_bytes),
    .sel        (sp_sel),
    .active     (sp_active),
    .lim_fault  (limit_fault)
  );

endmodule

// File: rtl/sst_tracker_chk.sv
module sst_tracker_chk #(
  parameter int DW = 32,
  parameter int XW = 9,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gw_valid,
  input logic          gw_callable,
  input logic          nsret_valid,
  input logic          exc_entry_valid,
  input logic          exc_entry_secure,
  input logic [XW-1:0] exc_entry_num,
  input logic          exc_return_valid,
  input logic          wr_valid,
  input logic          push_valid,
  input logic [PW-1:0] push_bytes,
  input logic          is_secure,
  input logic          is_handler,
  input logic [1:0]    sp_sel,
  input logic [DW-1:0] sp_active,
  input logic          sec_fault,
  input logic          limit_fault
);

  logic lone;
  assign lone = $onehot0({gw_valid, nsret_valid, exc_entry_valid,
                          exc_return_valid, wr_valid, push_valid});

  // R4
  gw_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_valid && lone && !is_secure && gw_callable)
      |=> ((sec_fault != is_secure) && $stable(is_handler)));

  // R5
  gw_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_valid && lone && !is_secure && !gw_callable)
      |=> (sec_fault && !is_secure && $stable(sp_sel)));

  // R6
  gw_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_valid && lone && is_secure)
      |=> (is_secure && !sec_fault && $stable(sp_sel)));

  // R8
  ret_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nsret_valid && lone) |=> $stable(is_handler));

  // R9
  ret_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nsret_valid && lone && !is_secure) |=> (sec_fault && !is_secure));

  // R3
  exc_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry_valid && lone && (exc_entry_num != '0))
      |=> (is_handler && (sp_sel == {$past(exc_entry_secure), 1'b0})));

  // R12
  push_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && lone && (push_bytes != '0))
      |=> (limit_fault != (sp_active != $past(sp_active))));

endmodule

bind sst_tracker sst_tracker_chk #(.DW(DW), .XW(XW), .PW(PW)) u_chk (.*);

// File: tb/tb_sst_tracker.sv
`timescale 1ns/1ps
module tb_sst_tracker;

  localparam logic [2:0] EV_IDLE = 3'd0, EV_GW = 3'd1, EV_RET = 3'd2, EV_XIN = 3'd3,
                         EV_XRT = 3'd4, EV_WR = 3'd5, EV_PU = 3'd6;

  typedef struct packed {
    logic [2:0]  ev;
    logic        flag;
    logic [8:0]  num;
    logic [2:0]  ws;
    logic [31:0] data;
    logic        esec;
    logic        ehnd;
    logic [1:0]  esel;
    logic [31:0] esp;
    logic        esf;
    logic        elf;
    logic [3:0]  req;
  } vec_t;

  logic        clk, rst_n;
  logic        gw_valid, gw_callable, nsret_valid;
  logic        exc_entry_valid, exc_entry_secure, exc_return_valid, exc_return_secure;
  logic [8:0]  exc_entry_num, exc_return_num;
  logic        wr_valid, push_valid;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic [7:0]  push_bytes;
  logic        is_secure, is_handler, sec_fault, limit_fault;
  logic [1:0]  sp_sel;
  logic [31:0] sp_active;

  int nchk, nfail;

  sst_tracker dut (
    .clk(clk), .rst_n(rst_n),
    .gw_valid(gw_valid), .gw_callable(gw_callable), .nsret_valid(nsret_valid),
    .exc_entry_valid(exc_entry_valid), .exc_entry_secure(exc_entry_secure),
    .exc_entry_num(exc_entry_num), .exc_return_valid(exc_return_valid),
    .exc_return_secure(exc_return_secure), .exc_return_num(exc_return_num),
    .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
    .push_valid(push_valid), .push_bytes(push_bytes),
    .is_secure(is_secure), .is_handler(is_handler), .sp_sel(sp_sel),
    .sp_active(sp_active), .sec_fault(sec_fault), .limit_fault(limit_fault)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Walked vectors: event, flag, number, write select, data | expected state
  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{EV_WR,  1'b0, 9'd0,  3'd3, 32'h2000_0100, 1'b1, 1'b0, 2'd3, 32'h2000_0100, 1'b0, 1'b0, 4'd10}, // R10
    '{EV_WR,  1'b0, 9'd0,  3'd5, 32'h2000_00F0, 1'b1, 1'b0, 2'd3, 32'h2000_0100, 1'b0, 1'b0, 4'd10},
    '{EV_WR,  1'b0, 9'd0,  3'd2, 32'h2000_1000, 1'b1, 1'b0, 2'd3, 32'h2000_0100, 1'b0, 1'b0, 4'd10},
    '{EV_WR,  1'b0, 9'd0,  3'd1, 32'h3000_0200, 1'b1, 1'b0, 2'd3, 32'h2000_0100, 1'b0, 1'b0, 4'd10},
    '{EV_WR,  1'b0, 9'd0,  3'd0, 32'h3000_2000, 1'b1, 1'b0, 2'd3, 32'h2000_0100, 1'b0, 1'b0, 4'd10},
    '{EV_WR,  1'b0, 9'd0,  3'd4, 32'h3000_0100, 1'b1, 1'b0, 2'd3, 32'h2000_0100, 1'b0, 1'b0, 4'd10},
    '{EV_PU,  1'b0, 9'd0,  3'd0, 32'h0000_0008, 1'b1, 1'b0, 2'd3, 32'h2000_00F8, 1'b0, 1'b0, 4'd12}, // R12
    '{EV_PU,  1'b0, 9'd0,  3'd0, 32'h0000_0010, 1'b1, 1'b0, 2'd3, 32'h2000_00F8, 1'b0, 1'b1, 4'd12},
    '{EV_XRT, 1'b0, 9'd0,  3'd0, 32'h0,         1'b0, 1'b0, 2'd1, 32'h3000_0200, 1'b0, 1'b0, 4'd2},  // R2
    '{EV_WR,  1'b0, 9'd0,  3'd3, 32'hDEAD_0000, 1'b0, 1'b0, 2'd1, 32'h3000_0200, 1'b0, 1'b0, 4'd11}, // R11
    '{EV_WR,  1'b0, 9'd0,  3'd5, 32'h0,         1'b0, 1'b0, 2'd1, 32'h3000_0200, 1'b0, 1'b0, 4'd11},
    '{EV_GW,  1'b0, 9'd0,  3'd0, 32'h0,         1'b0, 1'b0, 2'd1, 32'h3000_0200, 1'b1, 1'b0, 4'd5},  // R5
    '{EV_GW,  1'b1, 9'd0,  3'd0, 32'h0,         1'b1, 1'b0, 2'd3, 32'h2000_00F8, 1'b0, 1'b0, 4'd4},  // R4, R11
    '{EV_PU,  1'b0, 9'd0,  3'd0, 32'h0000_0008, 1'b1, 1'b0, 2'd3, 32'h2000_00F0, 1'b0, 1'b0, 4'd12},
    '{EV_GW,  1'b1, 9'd0,  3'd0, 32'h0,         1'b1, 1'b0, 2'd3, 32'h2000_00F0, 1'b0, 1'b0, 4'd6},  // R6
    '{EV_RET, 1'b0, 9'd0,  3'd0, 32'h0,         1'b0, 1'b0, 2'd1, 32'h3000_0200, 1'b0, 1'b0, 4'd8},  // R8
    '{EV_RET, 1'b0, 9'd0,  3'd0, 32'h0,         1'b0, 1'b0, 2'd1, 32'h3000_0200, 1'b1, 1'b0, 4'd9},  // R9
    '{EV_XIN, 1'b0, 9'd11, 3'd0, 32'h0,         1'b0, 1'b1, 2'd0, 32'h3000_2000, 1'b0, 1'b0, 4'd3},  // R3
    '{EV_PU,  1'b0, 9'd0,  3'd0, 32'h0000_0040, 1'b0, 1'b1, 2'd0, 32'h3000_1FC0, 1'b0, 1'b0, 4'd12},
    '{EV_GW,  1'b1, 9'd0,  3'd0, 32'h0,         1'b1, 1'b1, 2'd2, 32'h2000_1000, 1'b0, 1'b0, 4'd4},
    '{EV_WR,  1'b0, 9'd0,  3'd3, 32'h2000_0400, 1'b1, 1'b1, 2'd2, 32'h2000_1000, 1'b0, 1'b0, 4'd10},
    '{EV_RET, 1'b0, 9'd0,  3'd0, 32'h0,         1'b0, 1'b1, 2'd0, 32'h3000_1FC0, 1'b0, 1'b0, 4'd8},
    '{EV_XRT, 1'b0, 9'd0,  3'd0, 32'h0,         1'b0, 1'b0, 2'd1, 32'h3000_0200, 1'b0, 1'b0, 4'd2},
    '{EV_PU,  1'b0, 9'd0,  3'd0, 32'h0000_0080, 1'b0, 1'b0, 2'd1, 32'h3000_0180, 1'b0, 1'b0, 4'd12},
    '{EV_PU,  1'b0, 9'd0,  3'd0, 32'h0000_0084, 1'b0, 1'b0, 2'd1, 32'h3000_0180, 1'b0, 1'b1, 4'd12}
  };

  task automatic idle_inputs();
    gw_valid = 1'b0; gw_callable = 1'b0; nsret_valid = 1'b0;
    exc_entry_valid = 1'b0; exc_entry_secure = 1'b0; exc_entry_num = '0;
    exc_return_valid = 1'b0; exc_return_secure = 1'b0; exc_return_num = '0;
    wr_valid = 1'b0; wr_sel = '0; wr_data = '0;
    push_valid = 1'b0; push_bytes = '0;
  endtask

  task automatic check_out(input logic esec, input logic ehnd, input logic [1:0] esel,
                           input logic [31:0] esp, input logic esf, input logic elf,
                           input int req);
    nchk++;
    if ({is_secure, is_handler, sp_sel, sp_active, sec_fault, limit_fault} !==
        {esec, ehnd, esel, esp, esf, elf}) begin
      nfail++;
      $display("FAIL R%0d: actual sec=%b hnd=%b sel=%0d sp=%h sf=%b lf=%b expected sec=%b hnd=%b sel=%0d sp=%h sf=%b lf=%b",
               req, is_secure, is_handler, sp_sel, sp_active, sec_fault, limit_fault,
               esec, ehnd, esel, esp, esf, elf);
    end
  endtask

  task automatic run(input vec_t v);
    @(negedge clk);
    idle_inputs();
    case (v.ev)
      EV_GW:  begin gw_valid = 1'b1; gw_callable = v.flag; end
      EV_RET: nsret_valid = 1'b1;
      EV_XIN: begin exc_entry_valid = 1'b1; exc_entry_secure = v.flag; exc_entry_num = v.num; end
      EV_XRT: begin exc_return_valid = 1'b1; exc_return_secure = v.flag; exc_return_num = v.num; end
      EV_WR:  begin wr_valid = 1'b1; wr_sel = v.ws; wr_data = v.data; end
      EV_PU:  begin push_valid = 1'b1; push_bytes = v.data[7:0]; end
      default: ;
    endcase
    @(negedge clk);
    idle_inputs();
    check_out(v.esec, v.ehnd, v.esel, v.esp, v.esf, v.elf, int'(v.req));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R1: watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    nchk = 0;
    nfail = 0;
    idle_inputs();
    do_reset();
    // R1: reset state
    check_out(1'b1, 1'b0, 2'd3, 32'h0, 1'b0, 1'b0, 1);

    for (int i = 0; i < NV; i++) run(TBL[i]);

    // R4 from Non-Secure Thread, then nest calls up to the depth limit (R7)
    run('{EV_GW,  1'b1, 9'd0, 3'd0, 32'h0, 1'b1, 1'b0, 2'd3, 32'h2000_0400, 1'b0, 1'b0, 4'd4});
    run('{EV_XIN, 1'b0, 9'd3, 3'd0, 32'h0, 1'b0, 1'b1, 2'd0, 32'h3000_1FC0, 1'b0, 1'b0, 4'd2});
    run('{EV_GW,  1'b1, 9'd0, 3'd0, 32'h0, 1'b1, 1'b1, 2'd2, 32'h2000_1000, 1'b0, 1'b0, 4'd4});
    run('{EV_XIN, 1'b0, 9'd4, 3'd0, 32'h0, 1'b0, 1'b1, 2'd0, 32'h3000_1FC0, 1'b0, 1'b0, 4'd2});
    run('{EV_GW,  1'b1, 9'd0, 3'd0, 32'h0, 1'b1, 1'b1, 2'd2, 32'h2000_1000, 1'b0, 1'b0, 4'd7});
    run('{EV_XIN, 1'b0, 9'd5, 3'd0, 32'h0, 1'b0, 1'b1, 2'd0, 32'h3000_1FC0, 1'b0, 1'b0, 4'd2});
    run('{EV_GW,  1'b1, 9'd0, 3'd0, 32'h0, 1'b1, 1'b1, 2'd2, 32'h2000_1000, 1'b0, 1'b0, 4'd7});
    run('{EV_XIN, 1'b0, 9'd6, 3'd0, 32'h0, 1'b0, 1'b1, 2'd0, 32'h3000_1FC0, 1'b0, 1'b0, 4'd2});
    // R7: fifth outstanding call refused
    run('{EV_GW,  1'b1, 9'd0, 3'd0, 32'h0, 1'b0, 1'b1, 2'd0, 32'h3000_1FC0, 1'b1, 1'b0, 4'd7});
    // R9: return while Non-Secure
    run('{EV_RET, 1'b0, 9'd0, 3'd0, 32'h0, 1'b0, 1'b1, 2'd0, 32'h3000_1FC0, 1'b1, 1'b0, 4'd9});
    run('{EV_XIN, 1'b1, 9'd7, 3'd0, 32'h0, 1'b1, 1'b1, 2'd2, 32'h2000_1000, 1'b0, 1'b0, 4'd3});
    // R8: matching Handler-mode return pops one call
    run('{EV_RET, 1'b0, 9'd0, 3'd0, 32'h0, 1'b0, 1'b1, 2'd0, 32'h3000_1FC0, 1'b0, 1'b0, 4'd8});
    run('{EV_XRT, 1'b1, 9'd0, 3'd0, 32'h0, 1'b1, 1'b0, 2'd3, 32'h2000_0400, 1'b0, 1'b0, 4'd2});
    // R9: return in Thread mode against a call made from Handler mode
    run('{EV_RET, 1'b0, 9'd0, 3'd0, 32'h0, 1'b1, 1'b0, 2'd3, 32'h2000_0400, 1'b1, 1'b0, 4'd9});

    // R1: reset in mid-run clears everything
    do_reset();
    check_out(1'b1, 1'b0, 2'd3, 32'h0, 1'b0, 1'b0, 1);
    // R12: push that would wrap below zero on a process pointer
    run('{EV_PU, 1'b0, 9'd0, 3'd0, 32'h0000_0004, 1'b1, 1'b0, 2'd3, 32'h0, 1'b0, 1'b1, 4'd12});

    finish_run();
  end

endmodule